// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Character Error Flags

This block receives characters from one asynchronous serial line. It uses the same framing settings as the transmitter beside it: the parity mode, a 7-bit or 8-bit character, the bit order and a clock divisor. One bit lasts `2 × divisor` clock cycles. The block synchronises the line and waits for a falling edge. It confirms the start bit at the middle of that bit, then samples every data bit, the parity bit and the first stop bit at the centre of its bit time. The finished character goes into a receive data register.

The character can be read in two ways. `rd_byte` holds the character alone. `rd_word` holds the character in its low byte, the parity error flag of that character in bit 9 and the framing error flag in bit 8. A separate status register gathers error flags that stay set until cleared. A one-cycle `rx_irq` pulse marks each new character. The host reads a character by pulsing `rd_pop`. It clears status bits by pulsing `err_clr` with a mask of the bits to clear.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, `rd_byte`, `rd_word` and `err_status` are 0 and `rx_irq` is low.
- R2: With `pwr_on` and `rx_en` both high, the block receives a frame made of a low start bit, the data bits, an optional parity bit and a high stop bit, each lasting `2 × divisor` clocks. The character appears on `rd_byte` and on `rd_word[7:0]`. `rx_irq` is high for exactly one cycle for each character.
- R3: If `pwr_on` or `rx_en` is low, no character is received. `rx_irq` stays low and the data registers keep their contents.
- R4: `par_mode` selects the parity check: 00 means no parity bit, 01 means the parity bit must be 0, 10 means odd parity over data and parity bit, 11 means even parity. A mismatch sets `rd_word[9]` for that character and sets `err_status[2]`.
- R5: A low first stop bit sets `rd_word[8]` for that character and sets `err_status[1]`.
- R6: `lsb_first` = 1 sends data least significant bit first, and 0 sends it most significant bit first. `len8` = 0 selects 7 data bits, and then `rd_byte[7]` reads 0.
- R7: A single stop bit is enough. A frame that starts right after the stop bit of the previous frame is still received.
- R8: A low pulse that has ended before the middle of the start bit does not start a frame.
- R9: If a character completes while the previous one has not been taken by `rd_pop`, `err_status[0]` (overrun) is set and the new character replaces the old one.
- R10: An overrun that happens while `err_status[0]` is already set also sets `err_status[3]` (overflow).
- R11: Status bits stay set until a cycle with `err_clr` high clears each bit whose `err_clr_mask` bit is 1. Bits whose mask bit is 0 are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on | input | 1 | Channel clock enable |
| rx_en | input | 1 | Receive enable |
| lsb_first | input | 1 | Bit order, 1 = least significant bit first |
| par_mode | input | 2 | Parity check mode |
| len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| divisor | input | DIV_W | Half the bit time in clocks, at least 4 |
| rxd | input | 1 | Serial line input, idles high |
| rd_pop | input | 1 | Pulse to take the current character |
| rd_byte | output | 8 | Character view |
| rd_word | output | 16 | Character with parity flag (bit 9) and framing flag (bit 8) |
| err_clr | input | 1 | Pulse to clear the masked status bits |
| err_clr_mask | input | 4 | Status bits to clear |
| err_status | output | 4 | Sticky flags: overflow, parity, framing, overrun (bits 3 to 0) |
| rx_irq | output | 1 | One-cycle pulse for each new character |

## Verification
Characters are sent under every parity mode, under both bit orders and under both character lengths. The parity cases include a correct parity bit and a flipped one, so a wrong polarity in any mode shows up as a wrong bit 9. One frame has a low stop bit, to separate the framing flag from the parity flag. Two frames are sent back to back with no gap and without a read between them: this checks the single-stop-bit restart, the overrun flag, the overwrite of the old character and, after a third frame, the overflow flag. A short low glitch and frames sent while the channel is switched off must leave the interrupt count and the data unchanged.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam int CHAR_W = 8;
  localparam int STAT_W = 4;

  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_ZERO = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;
  localparam logic [1:0] PAR_EVEN = 2'b11;

  // True when the received parity bit does not match the selected mode.
  function automatic logic par_error(input logic [1:0] mode,
                                     input logic [CHAR_W-1:0] ch,
                                     input logic pbit);
    logic ones_odd;
    ones_odd = ^{ch, pbit};
    case (mode)
      PAR_ZERO: par_error = pbit;
      PAR_ODD:  par_error = !ones_odd;
      PAR_EVEN: par_error = ones_odd;
      default:  par_error = 1'b0;
    endcase
  endfunction

  // Register position of the idx-th received data bit.
  function automatic logic [2:0] bit_slot(input logic lsb_first,
                                          input logic len8,
                                          input logic [2:0] idx);
    if (lsb_first)
      bit_slot = idx;
    else if (len8)
      bit_slot = 3'd7 - idx;
    else
      bit_slot = 3'd6 - idx;
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pipe <= '1;
    else
      pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              lsb_first,
  input  logic              len8,
  input  logic [1:0]        par_mode,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              rx,
  output logic              done,
  output logic [CHAR_W-1:0] ch,
  output logic              pe,
  output logic              fe
);
  localparam int CNT_W = DIV_W + 1;

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        idx;
  logic [CHAR_W-1:0] shreg;
  logic              prev_rx;
  logic              pe_acc;

  logic [CNT_W-1:0] half_lim;
  logic [CNT_W-1:0] full_lim;
  logic             half_hit;
  logic             full_hit;
  logic [2:0]       last_idx;

  assign half_lim = {1'b0, divisor} - 1'b1;
  assign full_lim = {divisor, 1'b0} - 1'b1;
  assign half_hit = (cnt == half_lim);
  assign full_hit = (cnt == full_lim);
  assign last_idx = len8 ? 3'd7 : 3'd6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      prev_rx <= 1'b1;
      pe_acc  <= 1'b0;
      done    <= 1'b0;
      ch      <= '0;
      pe      <= 1'b0;
      fe      <= 1'b0;
    end else begin
      done    <= 1'b0;
      prev_rx <= rx;
      if (!active) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (prev_rx && !rx) state <= ST_START;
          end
          ST_START: begin
            if (half_hit) begin
              cnt <= '0;
              if (!rx) begin
                state  <= ST_DATA;
                idx    <= '0;
                shreg  <= '0;
                pe_acc <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (full_hit) begin
              cnt <= '0;
              shreg[bit_slot(lsb_first, len8, idx)] <= rx;
              idx <= idx + 1'b1;
              if (idx == last_idx)
                state <= (par_mode != PAR_NONE) ? ST_PAR : ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (full_hit) begin
              cnt    <= '0;
              pe_acc <= par_error(par_mode, shreg, rx);
              state  <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (full_hit) begin
              cnt   <= '0;
              done  <= 1'b1;
              ch    <= shreg;
              pe    <= pe_acc;
              fe    <= !rx;
              state <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on,
  input  logic             rx_en,
  input  logic             lsb_first,
  input  logic [1:0]       par_mode,
  input  logic             len8,
  input  logic [DIV_W-1:0] divisor,
  input  logic             rxd,
  input  logic             rd_pop,
  output logic [7:0]       rd_byte,
  output logic [15:0]      rd_word,
  input  logic             err_clr,
  input  logic [3:0]       err_clr_mask,
  output logic [3:0]       err_status,
  output logic             rx_irq
);
  localparam int OVR_BIT = 0;
  localparam int FRM_BIT = 1;
  localparam int PAR_BIT = 2;
  localparam int OVF_BIT = 3;

  logic              rx_sync;
  logic              rx_active;
  logic              frame_done;
  logic [CHAR_W-1:0] frame_ch;
  logic              frame_pe;
  logic              frame_fe;
  logic              buf_full;
  logic              lose_char;

  logic [CHAR_W-1:0] data_q;
  logic              pe_q;
  logic              fe_q;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_kept;
  logic [STAT_W-1:0] stat_new;

  assign rx_active = pwr_on & rx_en;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rx_sync)
  );

  uart_rx_frame #(.DIV_W(DIV_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (rx_active),
    .lsb_first(lsb_first),
    .len8     (len8),
    .par_mode (par_mode),
    .divisor  (divisor),
    .rx       (rx_sync),
    .done     (frame_done),
    .ch       (frame_ch),
    .pe       (frame_pe),
    .fe       (frame_fe)
  );

  assign lose_char = frame_done & buf_full & ~rd_pop;

  always_comb begin
    stat_kept = err_clr ? (stat_q & ~err_clr_mask) : stat_q;
    stat_new  = '0;
    if (frame_done) begin
      stat_new[OVR_BIT] = lose_char;
      stat_new[FRM_BIT] = frame_fe;
      stat_new[PAR_BIT] = frame_pe;
      stat_new[OVF_BIT] = lose_char & stat_q[OVR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      pe_q     <= 1'b0;
      fe_q     <= 1'b0;
      buf_full <= 1'b0;
      stat_q   <= '0;
    end else begin
      stat_q <= stat_kept | stat_new;
      if (frame_done) begin
        data_q   <= frame_ch;
        pe_q     <= frame_pe;
        fe_q     <= frame_fe;
        buf_full <= 1'b1;
      end else if (rd_pop) begin
        buf_full <= 1'b0;
      end
    end
  end

  assign rd_byte    = data_q;
  assign rd_word    = {6'b0, pe_q, fe_q, data_q};
  assign err_status = stat_q;
  assign rx_irq     = frame_done;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pwr_on,
  input logic        rx_en,
  input logic        len8,
  input logic [7:0]  rd_byte,
  input logic [15:0] rd_word,
  input logic        err_clr,
  input logic [3:0]  err_clr_mask,
  input logic [3:0]  err_status,
  input logic        rx_irq,
  input logic        lose_char,
  input logic        frame_fe
);
  // R2: each character is flagged by a single-cycle pulse
  a_r2_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  // R3: a switched-off channel raises no interrupt
  a_r3_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_on && rx_en) |=> !rx_irq);

  // R5: a bad stop bit shows in both the character flag and the status
  a_r5_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq && frame_fe |=> rd_word[8] && err_status[1]);

  // R6: a 7-bit character never has its top bit set
  a_r6_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq && !len8 && $stable(len8) |=> !rd_byte[7]);

  // R9: a lost character raises the overrun flag
  a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    lose_char |=> err_status[0]);

  // R11: flags hold until their own clear
  for (genvar k = 0; k < 4; k++) begin : g_sticky
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_status[k] && !(err_clr && err_clr_mask[k]) |=> err_status[k]);
  end
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_on      (pwr_on),
  .rx_en       (rx_en),
  .len8        (len8),
  .rd_byte     (rd_byte),
  .rd_word     (rd_word),
  .err_clr     (err_clr),
  .err_clr_mask(err_clr_mask),
  .err_status  (err_status),
  .rx_irq      (rx_irq),
  .lose_char   (lose_char),
  .frame_fe    (frame_fe)
);

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;
  localparam int CLK_P = 10;
  localparam int DIV   = 4;
  localparam int BIT_T = 2 * DIV;
  localparam int NVEC  = 9;

  // {cfg[5:0] = pwr,en,lsb,par[1:0],len8 ; char ; flip parity ; stop low ; expected word}
  localparam logic [31:0] VEC [NVEC] = '{
    {6'b111001, 8'hA5, 1'b0, 1'b0, 16'h00A5},
    {6'b111111, 8'h3C, 1'b0, 1'b0, 16'h003C},
    {6'b111101, 8'h81, 1'b1, 1'b0, 16'h0281},
    {6'b111000, 8'hFF, 1'b0, 1'b0, 16'h007F},
    {6'b110001, 8'h12, 1'b0, 1'b0, 16'h0012},
    {6'b111011, 8'h55, 1'b0, 1'b0, 16'h0055},
    {6'b111011, 8'h55, 1'b1, 1'b0, 16'h0255},
    {6'b111001, 8'hC3, 1'b0, 1'b1, 16'h01C3},
    {6'b111110, 8'h55, 1'b0, 1'b0, 16'h0055}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_on = 1'b0, rx_en = 1'b0, lsb_first = 1'b1, len8 = 1'b1;
  logic [1:0]  par_mode = 2'b00;
  logic [15:0] divisor = 16'(DIV);
  logic        rxd = 1'b1;
  logic        rd_pop = 1'b0;
  logic        err_clr = 1'b0;
  logic [3:0]  err_clr_mask = 4'b0;
  logic [7:0]  rd_byte;
  logic [15:0] rd_word;
  logic [3:0]  err_status;
  logic        rx_irq;

  int n_chk = 0;
  int n_err = 0;
  int irq_cnt = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (rx_irq) irq_cnt <= irq_cnt + 1;

  uart_rx_core dut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .rx_en(rx_en),
    .lsb_first(lsb_first), .par_mode(par_mode), .len8(len8),
    .divisor(divisor), .rxd(rxd), .rd_pop(rd_pop), .rd_byte(rd_byte),
    .rd_word(rd_word), .err_clr(err_clr), .err_clr_mask(err_clr_mask),
    .err_status(err_status), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [5:0] c);
    @(negedge clk);
    {pwr_on, rx_en, lsb_first, par_mode, len8} = c;
    repeat (2) @(negedge clk);
  endtask

  task automatic hold(input logic v);
    rxd = v;
    repeat (BIT_T) @(negedge clk);
  endtask

  // Sends one frame with one stop bit; gap adds idle bit times afterwards.
  task automatic send(input logic [7:0] ch, input logic flip, input logic stl, input int gap);
    int nb;
    logic [7:0] d;
    logic pb;
    nb = len8 ? 8 : 7;
    d  = len8 ? ch : (ch & 8'h7F);
    hold(1'b0);
    for (int i = 0; i < nb; i++)
      hold(lsb_first ? d[i] : d[nb-1-i]);
    if (par_mode != 2'b00) begin
      case (par_mode)
        2'b01:   pb = 1'b0;
        2'b10:   pb = ~^d;
        default: pb = ^d;
      endcase
      hold(pb ^ flip);
    end
    hold(!stl);
    rxd = 1'b1;
    repeat (gap * BIT_T) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk); rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0;
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk); err_clr = 1'b1; err_clr_mask = m;
    @(negedge clk); err_clr = 1'b0; err_clr_mask = 4'b0;
  endtask

  function automatic string vec_req(input int i);
    case (i)
      2, 5, 6: vec_req = "R4";
      3, 4:    vec_req = "R6";
      7:       vec_req = "R5";
      default: vec_req = "R2";
    endcase
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rd_word", rd_word, 16'h0);
    check("R1 status", {12'b0, err_status}, 16'h0);
    check("R1 irq", {15'b0, rx_irq}, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      set_cfg(VEC[i][31:26]);
      base = irq_cnt;
      send(VEC[i][25:18], VEC[i][17], VEC[i][16], 2);
      check(vec_req(i), rd_word, VEC[i][15:0]);
      check("R2 byte view", {8'b0, rd_byte}, {8'b0, VEC[i][7:0]});
      check("R2 irq count", 16'(irq_cnt - base), 16'd1);
      pop();
    end
    // R11: parity and framing flags gathered, then cleared by mask
    check("R11 sticky", {12'b0, err_status}, 16'h0006);
    clear(4'b0110);
    check("R11 cleared", {12'b0, err_status}, 16'h0000);

    // R3: powered off, then receive disabled
    base = irq_cnt;
    set_cfg(6'b011001);
    send(8'h99, 1'b0, 1'b0, 2);
    check("R3 no irq power off", 16'(irq_cnt - base), 16'd0);
    set_cfg(6'b101001);
    send(8'h66, 1'b0, 1'b0, 2);
    check("R3 no irq rx off", 16'(irq_cnt - base), 16'd0);
    check("R3 data kept", rd_word, 16'h0055);

    // R8: short glitch ignored
    set_cfg(6'b111001);
    @(negedge clk); rxd = 1'b0;
    repeat (2) @(negedge clk); rxd = 1'b1;
    repeat (4 * BIT_T) @(negedge clk);
    check("R8 glitch irq", 16'(irq_cnt - base), 16'd0);
    check("R8 glitch data", rd_word, 16'h0055);

    // R7 and R9: back-to-back frames with no read in between
    send(8'h11, 1'b0, 1'b0, 0);
    send(8'h22, 1'b0, 1'b0, 2);
    check("R7 both frames", 16'(irq_cnt - base), 16'd2);
    check("R9 overwrite", rd_word, 16'h0022);
    check("R9 overrun flag", {12'b0, err_status}, 16'h0001);
    // R10: another lost character while overrun is set
    send(8'h33, 1'b0, 1'b0, 2);
    check("R10 overflow flag", {12'b0, err_status}, 16'h0009);
    check("R10 data", rd_word, 16'h0033);
    // R11: selective clear
    clear(4'b0001);
    check("R11 selective", {12'b0, err_status}, 16'h0008);
    clear(4'b1000);
    check("R11 all clear", {12'b0, err_status}, 16'h0000);

    finish_run();
  end
endmodule